// File: doc/BRIEF.md
# Washer Cycle Controller with Rinse

This block is a Moore state machine that drives one complete laundry cycle. A single start pulse takes it out of its quiet state. It then runs a wash phase followed by a rinse phase, and each phase consists of a fill, an agitate and a spin step. The wash fill uses hot water and the rinse fill uses cold water. When the rinse spin ends, the block returns to its quiet state and waits for the next start.

Each fill step ends when the water-level sensor reports a full drum. Each agitate and spin step lasts a fixed number of clock cycles, set by a parameter for that step. An internal down-counter, reloaded each time a new step is entered, measures these durations. The four actuator outputs come from registers, so they change only at a clock edge and stay in line with the state register.

Top module: `washer_cycle_ctrl`

## Requirements
- R1: A high `rst_i` at a rising clock edge returns the machine to idle from any step, and all four outputs are low after that edge.
- R2: In idle all four outputs are low. The machine leaves idle only when `start_i` is high at a rising edge, and it then goes to the wash fill step.
- R3: The steps follow one fixed order: idle, wash fill, wash agitate, wash spin, rinse fill, rinse agitate, rinse spin, idle.
- R4: During the wash fill step only `hot_valve_o` is high.
- R5: During the rinse fill step only `cold_valve_o` is high.
- R6: A fill step ends at the first rising edge where `water_full_i` is high, and it holds while that input is low. If the sensor is already high on entry, the fill step lasts exactly one cycle.
- R7: During an agitate step only `agitator_o` is high. During a spin step only `spin_o` is high.
- R8: Each agitate and spin step lasts exactly its parameter's number of cycles. These are WASH_AGIT_CYC, WASH_SPIN_CYC, RINSE_AGIT_CYC and RINSE_SPIN_CYC, each 1 or more. A value of 1 gives a one-cycle step.
- R9: `start_i` has no effect outside idle. The step sequence and the outputs are the same whether it is held high or low.
- R10: After rinse spin the machine is in idle, and a new start pulse runs a complete new cycle.
- R11: At most one of the four outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to start a cycle, used only in idle |
| water_full_i | input | 1 | Drum full level sensor |
| hot_valve_o | output | 1 | Hot water inlet valve |
| cold_valve_o | output | 1 | Cold water inlet valve |
| agitator_o | output | 1 | Agitator motor enable |
| spin_o | output | 1 | Spin motor enable |

## Verification
The bench builds the block with wash agitate 3, wash spin 1, rinse agitate 4 and rinse spin 2 cycles. Every timed step therefore has a different length, and a step measured against the wrong parameter shows up as a wrong count. The one-cycle wash spin reaches the smallest duration, where the counter reload is also the finishing value. The bench holds the full sensor high on entry to reach the one-cycle fill case.

// File: rtl/washer_pkg.sv
package washer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WFILL = 3'd1,
        ST_WAGIT = 3'd2,
        ST_WSPIN = 3'd3,
        ST_RFILL = 3'd4,
        ST_RAGIT = 3'd5,
        ST_RSPIN = 3'd6
    } wash_state_e;

    typedef struct packed {
        logic hot;
        logic cold;
        logic agit;
        logic spin;
    } drive_t;

    localparam drive_t DRIVE_OFF = '{hot: 1'b0, cold: 1'b0, agit: 1'b0, spin: 1'b0};

    function automatic wash_state_e step_after(input wash_state_e s);
        case (s)
            ST_IDLE:  return ST_WFILL;
            ST_WFILL: return ST_WAGIT;
            ST_WAGIT: return ST_WSPIN;
            ST_WSPIN: return ST_RFILL;
            ST_RFILL: return ST_RAGIT;
            ST_RAGIT: return ST_RSPIN;
            default:  return ST_IDLE;
        endcase
    endfunction

    function automatic logic is_fill(input wash_state_e s);
        return (s == ST_WFILL) || (s == ST_RFILL);
    endfunction

    function automatic logic is_timed(input wash_state_e s);
        return (s == ST_WAGIT) || (s == ST_WSPIN) ||
               (s == ST_RAGIT) || (s == ST_RSPIN);
    endfunction

    function automatic drive_t drive_of(input wash_state_e s);
        drive_t d;
        d = DRIVE_OFF;
        case (s)
            ST_WFILL: d.hot  = 1'b1;
            ST_RFILL: d.cold = 1'b1;
            ST_WAGIT,
            ST_RAGIT: d.agit = 1'b1;
            ST_WSPIN,
            ST_RSPIN: d.spin = 1'b1;
            default:  d = DRIVE_OFF;
        endcase
        return d;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/washer_step_timer.sv
module washer_step_timer
    import washer_pkg::*;
#(
    parameter int WASH_AGIT_CYC  = 5,
    parameter int WASH_SPIN_CYC  = 7,
    parameter int RINSE_AGIT_CYC = 4,
    parameter int RINSE_SPIN_CYC = 6,
    localparam int MAX_DUR = max2(max2(WASH_AGIT_CYC, WASH_SPIN_CYC),
                                  max2(RINSE_AGIT_CYC, RINSE_SPIN_CYC)),
    localparam int CNT_W   = (MAX_DUR > 1) ? $clog2(MAX_DUR) : 1
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        load_i,
    input  wash_state_e next_i,
    output logic        done_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        case (next_i)
            ST_WAGIT: reload = CNT_W'(WASH_AGIT_CYC - 1);
            ST_WSPIN: reload = CNT_W'(WASH_SPIN_CYC - 1);
            ST_RAGIT: reload = CNT_W'(RINSE_AGIT_CYC - 1);
            ST_RSPIN: reload = CNT_W'(RINSE_SPIN_CYC - 1);
            default:  reload = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    AST_CNT_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= CNT_W'(MAX_DUR - 1)); // R8

endmodule

// File: rtl/washer_sequencer.sv
module washer_sequencer
    import washer_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        start_i,
    input  logic        water_full_i,
    input  logic        timer_done_i,
    output wash_state_e state_o,
    output wash_state_e next_o,
    output logic        enter_o
);

    wash_state_e state_q;
    wash_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (state_q == ST_IDLE) begin
            if (start_i) state_d = ST_WFILL;
        end else if (is_fill(state_q)) begin
            if (water_full_i) state_d = step_after(state_q);
        end else if (is_timed(state_q)) begin
            if (timer_done_i) state_d = step_after(state_q);
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    assign state_o = state_q;
    assign next_o  = rst_i ? ST_IDLE : state_d;
    assign enter_o = !rst_i && (state_d != state_q);

    AST_STEP_ORDER: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && state_q != $past(state_q)) |->
            (state_q == step_after($past(state_q)))); // R3

    AST_FILL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_fill(state_q) && !water_full_i) |=> (state_q == $past(state_q))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE)); // R2

endmodule

// File: rtl/washer_drive_reg.sv
module washer_drive_reg
    import washer_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  wash_state_e next_i,
    input  wash_state_e state_i,
    output drive_t      drive_o
);

    drive_t drv_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) drv_q <= DRIVE_OFF;
        else       drv_q <= drive_of(next_i);
    end

    assign drive_o = drv_q;

    AST_ONE_DRIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(drv_q)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_IDLE) |-> (drv_q == DRIVE_OFF)); // R2

    AST_HOT_WASH: assert property (@(posedge clk_i) disable iff (rst_i)
        drv_q.hot |-> (state_i == ST_WFILL)); // R4

    AST_COLD_RINSE: assert property (@(posedge clk_i) disable iff (rst_i)
        drv_q.cold |-> (state_i == ST_RFILL)); // R5

    AST_AGIT_SPIN: assert property (@(posedge clk_i) disable iff (rst_i)
        (drv_q.agit || drv_q.spin) |-> is_timed(state_i)); // R7

endmodule

// File: rtl/washer_cycle_ctrl.sv
module washer_cycle_ctrl
    import washer_pkg::*;
#(
    parameter int WASH_AGIT_CYC  = 5,
    parameter int WASH_SPIN_CYC  = 7,
    parameter int RINSE_AGIT_CYC = 4,
    parameter int RINSE_SPIN_CYC = 6
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic water_full_i,
    output logic hot_valve_o,
    output logic cold_valve_o,
    output logic agitator_o,
    output logic spin_o
);

    wash_state_e state;
    wash_state_e state_next;
    logic        enter;
    logic        timer_done;
    drive_t      drive;

    initial begin
        assert (WASH_AGIT_CYC >= 1 && WASH_SPIN_CYC >= 1 &&
                RINSE_AGIT_CYC >= 1 && RINSE_SPIN_CYC >= 1); // R8
    end

    washer_sequencer u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .start_i     (start_i),
        .water_full_i(water_full_i),
        .timer_done_i(timer_done),
        .state_o     (state),
        .next_o      (state_next),
        .enter_o     (enter)
    );

    washer_step_timer #(
        .WASH_AGIT_CYC (WASH_AGIT_CYC),
        .WASH_SPIN_CYC (WASH_SPIN_CYC),
        .RINSE_AGIT_CYC(RINSE_AGIT_CYC),
        .RINSE_SPIN_CYC(RINSE_SPIN_CYC)
    ) u_timer (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .load_i(enter),
        .next_i(state_next),
        .done_o(timer_done)
    );

    washer_drive_reg u_drive (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .next_i (state_next),
        .state_i(state),
        .drive_o(drive)
    );

    assign hot_valve_o  = drive.hot;
    assign cold_valve_o = drive.cold;
    assign agitator_o   = drive.agit;
    assign spin_o       = drive.spin;

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!hot_valve_o && !cold_valve_o && !agitator_o && !spin_o)); // R1

endmodule

// File: tb/sim_washer_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_washer_cycle_ctrl;

    localparam int WA = 3;
    localparam int WS = 1;
    localparam int RA = 4;
    localparam int RS = 2;

    localparam logic [3:0] P_OFF  = 4'b0000;
    localparam logic [3:0] P_HOT  = 4'b1000;
    localparam logic [3:0] P_COLD = 4'b0100;
    localparam logic [3:0] P_AGIT = 4'b0010;
    localparam logic [3:0] P_SPIN = 4'b0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic full = 1'b0;
    logic hot, cold, agit, spin;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    washer_cycle_ctrl #(
        .WASH_AGIT_CYC(WA), .WASH_SPIN_CYC(WS),
        .RINSE_AGIT_CYC(RA), .RINSE_SPIN_CYC(RS)
    ) u0 (
        .clk_i(clk), .rst_i(rst), .start_i(start), .water_full_i(full),
        .hot_valve_o(hot), .cold_valve_o(cold), .agitator_o(agit), .spin_o(spin)
    );

    function automatic logic [3:0] outs();
        return {hot, cold, agit, spin};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // at a negedge where the fill step is visible; lasts waits+1 samples
    task automatic fill_step(input string tag, input logic [3:0] pat, input int waits);
        for (int i = 0; i < waits; i++) begin
            check(tag, {28'd0, outs()}, {28'd0, pat});
            @(negedge clk);
        end
        check(tag, {28'd0, outs()}, {28'd0, pat});
        full = 1'b1;
        @(negedge clk);
        full = 1'b0;
    endtask

    task automatic timed_step(input string tag, input logic [3:0] pat, input int len);
        int n = 0;
        while (outs() == pat && n < 100) begin
            n++;
            @(negedge clk);
        end
        check(tag, n, len);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 reset outputs", {28'd0, outs()}, {28'd0, P_OFF});
        rst = 1'b0;
        full = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 idle stays without start", {28'd0, outs()}, {28'd0, P_OFF});
        full = 1'b0;
    endtask

    task automatic t_full_cycle(input string tag, input int wwait, input int rwait);
        pulse_start();
        fill_step({"R4 wash fill hot ", tag}, P_HOT, wwait);
        timed_step({"R7 R8 wash agit ", tag}, P_AGIT, WA);
        timed_step({"R7 R8 wash spin ", tag}, P_SPIN, WS);
        fill_step({"R5 rinse fill cold ", tag}, P_COLD, rwait);
        timed_step({"R7 R8 rinse agit ", tag}, P_AGIT, RA);
        timed_step({"R7 R8 rinse spin ", tag}, P_SPIN, RS);
        check({"R3 R10 back to idle ", tag}, {28'd0, outs()}, {28'd0, P_OFF});
        repeat (2) @(negedge clk);
        check({"R10 idle holds ", tag}, {28'd0, outs()}, {28'd0, P_OFF});
    endtask

    task automatic t_fast_fill();
        full = 1'b1;
        pulse_start();
        check("R6 wash fill one cycle", {28'd0, outs()}, {28'd0, P_HOT});
        @(negedge clk);
        timed_step("R8 agit after fast fill", P_AGIT, WA);
        timed_step("R8 spin after fast fill", P_SPIN, WS);
        check("R6 rinse fill one cycle", {28'd0, outs()}, {28'd0, P_COLD});
        @(negedge clk);
        full = 1'b0;
        timed_step("R8 rinse agit fast", P_AGIT, RA);
        timed_step("R8 rinse spin fast", P_SPIN, RS);
        check("R10 idle after fast", {28'd0, outs()}, {28'd0, P_OFF});
    endtask

    task automatic t_start_ignored();
        pulse_start();
        start = 1'b1;
        fill_step("R9 fill with start high", P_HOT, 2);
        timed_step("R9 agit with start high", P_AGIT, WA);
        timed_step("R9 spin with start high", P_SPIN, WS);
        start = 1'b0;
        fill_step("R9 rinse fill", P_COLD, 1);
        timed_step("R9 rinse agit", P_AGIT, RA);
        timed_step("R9 rinse spin", P_SPIN, RS);
        check("R9 idle at end", {28'd0, outs()}, {28'd0, P_OFF});
    endtask

    task automatic t_mid_reset();
        pulse_start();
        fill_step("R1 pre-reset fill", P_HOT, 0);
        timed_step("R1 pre-reset agit", P_AGIT, WA);
        timed_step("R1 pre-reset spin", P_SPIN, WS);
        fill_step("R1 pre-reset rinse fill", P_COLD, 0);
        @(negedge clk);
        check("R1 in rinse agit", {28'd0, outs()}, {28'd0, P_AGIT});
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid cycle", {28'd0, outs()}, {28'd0, P_OFF});
        rst = 1'b0;
        full = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 R2 idle after reset", {28'd0, outs()}, {28'd0, P_OFF});
        full = 1'b0;
        t_full_cycle("after reset", 1, 0);
    endtask

    always @(negedge clk) begin
        if (!rst && ((hot + cold + agit + spin) > 1)) begin
            errors++;
            checks++;
            $display("FAIL R11: actual %b expected at most one high", outs());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_full_cycle("slow", 3, 2);
        t_fast_fill();
        t_start_ignored();
        t_mid_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule